// File: doc/BRIEF.md
# Host/DSP Command and Reply Mailbox

This block carries short messages between a host processor and a DSP core over a set of independent channels. The default build has three channels. Each channel has a 16-bit command register and a 16-bit reply register. The host writes a command and the DSP picks it up. The DSP posts a reply and the host collects it.

Each channel keeps two handshake flags, and both are active-low: a 0 means the event has happened.
- The command flag drops to 0 when the DSP reads the command. A fresh host write raises it back to 1.
- The reply flag drops to 0 when the DSP writes a reply. A host read of that reply raises it back to 1.

A per-channel enable lets a pending reply raise the host interrupt. Command consumption never raises the interrupt.

Both sides use plain single-cycle register ports with combinational read data. Read side effects take place at the clock edge that ends the access cycle.

Top module: `dsp_mailbox`

## Requirements
- R1: After reset, every command and reply register reads 0, every handshake flag reads 1 (status word 0x003F), all interrupt enables read 0 and `host_irq` is 0.
- R2: The host map is decoded as follows; every other bit reads 0:
  - Address k (0..2) is command register k, which the host can read and write.
  - Address 3+k is reply register k, which the host can only read.
  - Address 6 is the control word, and its bit k enables the interrupt for reply k.
  - Address 7 is the read-only status word. Bit k is the reply-k flag and bit 3+k is the command-k flag.
- R3: A DSP read with `dsp_addr`=k returns command k on `dsp_rdata` in the same cycle, and the command-k flag reads 0 from the next cycle on.
- R4: A host write to command k stores the data and sets the command-k flag to 1. When it falls in the same cycle as a DSP read of channel k, the DSP sees the old data and the flag ends at 1.
- R5: A DSP write with `dsp_addr`=k stores reply k, and from the next cycle the host reads the new data at address 3+k with the reply-k flag at 0.
- R6: A host read of reply k sets the reply-k flag to 1 from the next cycle and leaves the reply data unchanged.
- R7: When a DSP write to reply k and a host read of reply k fall in the same cycle, the host sees the old data, the new data is kept, and the reply-k flag reads 0.
- R8: `host_irq` is 1 exactly while some channel k has its reply flag at 0 and control bit k at 1. It follows flag and enable changes without added delay.
- R9: The following accesses are ignored and change no register or flag; a DSP read with a channel index of 3 or more returns 0.
  - Host writes to reply or status addresses.
  - DSP accesses with a channel index of 3 or more.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe |
| host_rd_en | input | 1 | Host read strobe; a read of a reply address has a side effect |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, combinational from `host_addr` |
| host_irq | output | 1 | Host interrupt for enabled pending replies |
| dsp_wr_en | input | 1 | DSP reply write strobe |
| dsp_rd_en | input | 1 | DSP command read strobe |
| dsp_addr | input | 2 | DSP channel index |
| dsp_wdata | input | 16 | DSP reply data |
| dsp_rdata | output | 16 | Command data for the selected channel, or 0 when the index is out of range |

## Verification
The bench builds the block with its defaults: three channels and 16-bit data. With three channels every host address from 0 to 7 has a meaning. The 2-bit DSP index also has one unused code, 3, so the out-of-range DSP path can be exercised directly. Sixteen-bit data leaves the status bits above the six flags free, which lets the bench confirm that they read 0. The two same-cycle collisions and the interrupt enable masking are driven on distinct channels, so that a wrong channel decode also shows up.

// File: rtl/mbx_pkg.sv
// Package: shared types and the host address decode for the mailbox.
// Assumes the host map is laid out as: commands, replies, control, status.
package mbx_pkg;

    typedef enum logic [2:0] {
        RGN_CMD,
        RGN_REP,
        RGN_CTRL,
        RGN_STAT,
        RGN_NONE
    } host_region_e;

    // Classify a host address for a mailbox with nch channels.
    function automatic host_region_e host_region(input int unsigned addr,
                                                 input int unsigned nch);
        if (addr < nch)             return RGN_CMD;
        else if (addr < 2 * nch)    return RGN_REP;
        else if (addr == 2 * nch)   return RGN_CTRL;
        else if (addr == 2 * nch + 1) return RGN_STAT;
        else                        return RGN_NONE;
    endfunction

endpackage

// File: rtl/mbx_cmd_slot.sv
// Module: one command channel (host to DSP).
// Holds the command word and its active-low "consumed" flag.
// Assumes: when the host writes and the DSP reads in the same cycle,
// the host write wins and the flag stays 1.
module mbx_cmd_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              dsp_rd,
    output logic [DATA_W-1:0] data,
    output logic              rd_n
);

    // Store command data and track whether the DSP has consumed it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
            rd_n <= 1'b1;
        end else if (host_wr) begin
            data <= host_wdata;
            rd_n <= 1'b1;
        end else if (dsp_rd) begin
            rd_n <= 1'b0;
        end
    end

    // R3: a DSP read with no host write clears the flag
    a_r3_dsp_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_rd && !host_wr) |=> !rd_n);

    // R4: a host write stores the data and re-arms the flag
    a_r4_host_write_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr |=> (rd_n && data == $past(host_wdata)));

    // R3: data does not move without a host write
    a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_wr |=> $stable(data));

endmodule

// File: rtl/mbx_reply_slot.sv
// Module: one reply channel (DSP to host).
// Holds the reply word and its active-low "updated" flag.
// Assumes: when the DSP writes and the host reads in the same cycle,
// the DSP write wins, so the new data is kept and the flag is 0.
module mbx_reply_slot #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_wr,
    input  logic [DATA_W-1:0] dsp_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] data,
    output logic              upd_n
);

    // Store reply data and track whether the host has collected it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            upd_n <= 1'b1;
        end else if (dsp_wr) begin
            data  <= dsp_wdata;
            upd_n <= 1'b0;
        end else if (host_rd) begin
            upd_n <= 1'b1;
        end
    end

    // R5: a DSP write stores the data and drops the flag
    a_r5_dsp_write_posts: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_wr |=> (!upd_n && data == $past(dsp_wdata)));

    // R6: a host read alone re-arms the flag and keeps the data
    a_r6_host_read_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !dsp_wr) |=> (upd_n && $stable(data)));

    // R7: a collision leaves the flag low
    a_r7_collision_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && dsp_wr) |=> !upd_n);

endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: reply interrupt enables and the host interrupt output.
// Assumes the reply flags are active-low. The interrupt is a plain OR
// over the enabled pending replies, with no added register stage.
module mbx_irq_ctrl #(
    parameter int unsigned NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_wr,
    input  logic [NUM_CH-1:0] en_wdata,
    input  logic [NUM_CH-1:0] rep_upd_n,
    output logic [NUM_CH-1:0] en,
    output logic              irq
);

    // Hold the per-reply interrupt enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_wr) begin
            en <= en_wdata;
        end
    end

    // Raise the interrupt for any enabled reply still pending.
    always_comb begin
        irq = |(~rep_upd_n & en);
    end

    // R2: the enable register follows a control write
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr |=> en == $past(en_wdata));

    // R8: with no enables set, the interrupt stays low
    a_r8_no_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq);

endmodule

// File: rtl/dsp_mailbox.sv
// Module: top of the host/DSP command and reply mailbox.
// Decodes the host map (commands, replies, control, status), selects a
// DSP channel by index and instantiates one command slot and one reply
// slot per channel. Read data on both ports is combinational.
// Assumes single-cycle strobes and a single clock for both sides.
module dsp_mailbox #(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned DATA_W = 16,
    localparam int unsigned HOST_AW = $clog2(2 * NUM_CH + 2),
    localparam int unsigned DSP_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr_en,
    input  logic               host_rd_en,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    output logic               host_irq,
    input  logic               dsp_wr_en,
    input  logic               dsp_rd_en,
    input  logic [DSP_AW-1:0]  dsp_addr,
    input  logic [DATA_W-1:0]  dsp_wdata,
    output logic [DATA_W-1:0]  dsp_rdata
);
    import mbx_pkg::*;

    localparam int unsigned REP_BASE = NUM_CH;

    host_region_e      rgn;
    logic              dsp_ok;
    logic [DATA_W-1:0] cmd_data [NUM_CH];
    logic [DATA_W-1:0] rep_data [NUM_CH];
    logic [NUM_CH-1:0] cmd_rd_n;
    logic [NUM_CH-1:0] rep_upd_n;
    logic [NUM_CH-1:0] irq_en;
    logic [DATA_W-1:0] stat_word;
    logic [DATA_W-1:0] ctrl_word;

    // Classify the host address and check the DSP channel index.
    always_comb begin
        rgn    = host_region(int'(host_addr), NUM_CH);
        dsp_ok = (int'(dsp_addr) < NUM_CH);
    end

    // One command slot and one reply slot for each channel.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic cmd_wr_k, dsp_rd_k, dsp_wr_k, rep_rd_k;

        // Per-channel strobes from the two decoders.
        always_comb begin
            cmd_wr_k = host_wr_en && (host_addr == HOST_AW'(k));
            rep_rd_k = host_rd_en && (host_addr == HOST_AW'(REP_BASE + k));
            dsp_rd_k = dsp_rd_en  && (dsp_addr == DSP_AW'(k));
            dsp_wr_k = dsp_wr_en  && (dsp_addr == DSP_AW'(k));
        end

        mbx_cmd_slot #(.DATA_W(DATA_W)) u_cmd (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_wr    (cmd_wr_k),
            .host_wdata (host_wdata),
            .dsp_rd     (dsp_rd_k),
            .data       (cmd_data[k]),
            .rd_n       (cmd_rd_n[k])
        );

        mbx_reply_slot #(.DATA_W(DATA_W)) u_rep (
            .clk       (clk),
            .rst_n     (rst_n),
            .dsp_wr    (dsp_wr_k),
            .dsp_wdata (dsp_wdata),
            .host_rd   (rep_rd_k),
            .data      (rep_data[k]),
            .upd_n     (rep_upd_n[k])
        );
    end

    mbx_irq_ctrl #(.NUM_CH(NUM_CH)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr     (host_wr_en && rgn == RGN_CTRL),
        .en_wdata  (host_wdata[NUM_CH-1:0]),
        .rep_upd_n (rep_upd_n),
        .en        (irq_en),
        .irq       (host_irq)
    );

    // Pack the status and control words, with unused bits at 0.
    always_comb begin
        stat_word = '0;
        stat_word[NUM_CH-1:0]        = rep_upd_n;
        stat_word[2*NUM_CH-1:NUM_CH] = cmd_rd_n;
        ctrl_word = '0;
        ctrl_word[NUM_CH-1:0] = irq_en;
    end

    // Host read data multiplexer.
    always_comb begin
        host_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (rgn == RGN_CMD && host_addr == HOST_AW'(k))
                host_rdata = cmd_data[k];
            if (rgn == RGN_REP && host_addr == HOST_AW'(REP_BASE + k))
                host_rdata = rep_data[k];
        end
        if (rgn == RGN_CTRL) host_rdata = ctrl_word;
        if (rgn == RGN_STAT) host_rdata = stat_word;
    end

    // DSP read data multiplexer.
    always_comb begin
        dsp_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (dsp_ok && dsp_addr == DSP_AW'(k)) dsp_rdata = cmd_data[k];
        end
    end

    // R9: an out-of-range DSP index reads 0
    a_r9_dsp_oob_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !dsp_ok |-> dsp_rdata == '0);

    // R9: DSP strobes with an out-of-range index leave every flag alone
    a_r9_dsp_oob_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsp_ok && !host_wr_en && !host_rd_en) |=>
            ($stable(rep_upd_n) && $stable(cmd_rd_n)));

    // R8: with every reply collected, no interrupt
    a_r8_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (&rep_upd_n) |-> !host_irq);

    // R2: status bits above the flags stay 0
    a_r2_status_pad: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_STAT) |-> (host_rdata >> (2 * NUM_CH)) == '0);

endmodule

// File: tb/dsp_mailbox_tb.sv
// Scoreboard bench: drivers queue expected values and a monitor compares them.
module dsp_mailbox_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SRC_HOST = 0;
    localparam int SRC_DSP  = 1;
    localparam int SRC_IRQ  = 2;

    typedef struct {
        int          src;
        string       req;
        logic [15:0] exp;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
    logic [2:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_irq;
    logic        dsp_wr_en = 1'b0, dsp_rd_en = 1'b0;
    logic [1:0]  dsp_addr = '0;
    logic [15:0] dsp_wdata = '0;
    logic [15:0] dsp_rdata;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 1'b0;
    item_t q[$];

    dsp_mailbox u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_rd_en (host_rd_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_irq   (host_irq),
        .dsp_wr_en  (dsp_wr_en),
        .dsp_rd_en  (dsp_rd_en),
        .dsp_addr   (dsp_addr),
        .dsp_wdata  (dsp_wdata),
        .dsp_rdata  (dsp_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.src)
                SRC_HOST: act = host_rdata;
                SRC_DSP:  act = dsp_rdata;
                default:  act = {15'd0, host_irq};
            endcase
            n_tests++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s src=%0d actual=0x%04h expected=0x%04h",
                         it.req, it.src, act, it.exp);
            end
        end
    end

    function automatic void push(input int src, input string req, input logic [15:0] exp);
        item_t it;
        it.src = src; it.req = req; it.exp = exp;
        q.push_back(it);
    endfunction

    task automatic idle();
        host_wr_en = 0; host_rd_en = 0; dsp_wr_en = 0; dsp_rd_en = 0;
    endtask

    task automatic hwr(input logic [2:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        host_addr = a; host_wdata = d; host_wr_en = 1;
        @(posedge clk); #1; idle();
    endtask

    task automatic hrd(input logic [2:0] a, input logic [15:0] exp, input string req);
        @(posedge clk); #1;
        host_addr = a; host_rd_en = 1;
        push(SRC_HOST, req, exp);
        @(posedge clk); #1; idle();
    endtask

    task automatic drd(input logic [1:0] ch, input logic [15:0] exp, input string req);
        @(posedge clk); #1;
        dsp_addr = ch; dsp_rd_en = 1;
        push(SRC_DSP, req, exp);
        @(posedge clk); #1; idle();
    endtask

    task automatic dwr(input logic [1:0] ch, input logic [15:0] d);
        @(posedge clk); #1;
        dsp_addr = ch; dsp_wdata = d; dsp_wr_en = 1;
        @(posedge clk); #1; idle();
    endtask

    task automatic irq_chk(input logic exp, input string req);
        @(posedge clk); #1;
        push(SRC_IRQ, req, {15'd0, exp});
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        hrd(3'd7, 16'h003F, "R1 status");
        hrd(3'd0, 16'h0000, "R1 cmd0");
        hrd(3'd4, 16'h0000, "R1 rep1");
        hrd(3'd6, 16'h0000, "R1 ctrl");
        irq_chk(1'b0, "R1 irq");

        // R2, R4: command writes land at their own addresses
        hwr(3'd0, 16'h1111);
        hwr(3'd1, 16'h2222);
        hwr(3'd2, 16'h3333);
        hrd(3'd0, 16'h1111, "R2 cmd0");
        hrd(3'd1, 16'h2222, "R2 cmd1");
        hrd(3'd2, 16'h3333, "R2 cmd2");
        hrd(3'd7, 16'h003F, "R4 flags stay 1");

        // R3: DSP consumes command 1 (status bit 4 drops)
        drd(2'd1, 16'h2222, "R3 dsp data");
        hrd(3'd7, 16'h002F, "R3 cmd1 flag");

        // R4: a new host write re-arms it
        hwr(3'd1, 16'hABCD);
        hrd(3'd7, 16'h003F, "R4 rearm");

        // R4: host write and DSP read of channel 2 in the same cycle
        @(posedge clk); #1;
        host_addr = 3'd2; host_wdata = 16'h4444; host_wr_en = 1;
        dsp_addr = 2'd2; dsp_rd_en = 1;
        push(SRC_DSP, "R4 collision old data", 16'h3333);
        @(posedge clk); #1; idle();
        hrd(3'd7, 16'h003F, "R4 collision flag");
        hrd(3'd2, 16'h4444, "R4 collision data");

        // R9: ignored accesses
        drd(2'd3, 16'h0000, "R9 dsp oob read");
        hrd(3'd7, 16'h003F, "R9 oob read no flag");
        dwr(2'd3, 16'hDEAD);
        hwr(3'd3, 16'hFFFF);
        hwr(3'd7, 16'h0000);
        hrd(3'd7, 16'h003F, "R9 status untouched");
        hrd(3'd3, 16'h0000, "R9 rep0");
        hrd(3'd4, 16'h0000, "R9 rep1");
        hrd(3'd5, 16'h0000, "R9 rep2");

        // R5: DSP reply on channel 0
        dwr(2'd0, 16'h5A5A);
        hrd(3'd7, 16'h003E, "R5 rep0 flag");
        irq_chk(1'b0, "R8 disabled");

        // R8: enables gate the interrupt; R2 control readback
        hwr(3'd6, 16'h0001);
        hrd(3'd6, 16'h0001, "R2 ctrl");
        irq_chk(1'b1, "R8 enabled");
        hwr(3'd6, 16'h0002);
        irq_chk(1'b0, "R8 other enable");
        hwr(3'd6, 16'hFFFF);
        hrd(3'd6, 16'h0007, "R2 ctrl pad");
        irq_chk(1'b1, "R8 all enabled");

        // R6: host collects reply 0
        hrd(3'd3, 16'h5A5A, "R5 rep0 data");
        hrd(3'd7, 16'h003F, "R6 rearm");
        irq_chk(1'b0, "R8 after collect");
        hrd(3'd3, 16'h5A5A, "R6 data kept");

        // R7: DSP write and host read of reply 2 in the same cycle
        dwr(2'd2, 16'h0102);
        @(posedge clk); #1;
        host_addr = 3'd5; host_rd_en = 1;
        dsp_addr = 2'd2; dsp_wdata = 16'h0BAD; dsp_wr_en = 1;
        push(SRC_HOST, "R7 old data seen", 16'h0102);
        @(posedge clk); #1; idle();
        hrd(3'd7, 16'h003B, "R7 flag low");
        irq_chk(1'b1, "R7 irq");
        hrd(3'd5, 16'h0BAD, "R7 new data");
        hrd(3'd7, 16'h003F, "R7 collected");

        // R8: only channel 2 enabled, channel 1 pending must not interrupt
        hwr(3'd6, 16'h0004);
        dwr(2'd1, 16'h0011);
        dwr(2'd2, 16'h0022);
        irq_chk(1'b1, "R8 ch2 pending");
        hrd(3'd5, 16'h0022, "R8 rep2 data");
        irq_chk(1'b0, "R8 ch1 masked");
        hrd(3'd7, 16'h003D, "R8 ch1 still pending");

        @(posedge clk); #1;
        done = 1'b1;
        summary();
        $finish;
    end

endmodule